// File: doc/BRIEF.md
# Paged EEPROM Write Controller

This block sits between a CPU-side register bus and a small byte-wide data EEPROM, modelled here as a register array. The array takes a fixed programming time, given in clock cycles. A control register, selected by `reg_sel`, arms writing, selects row-parallel mode, starts a row commit and puts the array into standby. Array reads take one cycle, as RAM reads do, while no programming is under way.

In byte mode, one accepted array write starts a timed programming cycle. The new byte reaches the array when that cycle ends. In row-parallel mode, array writes fill eight volatile latches that belong to one 8-byte row, and no programming starts. The row is taken from the address of the first write after the latches were cleared. Writing the start bit then programs every latched byte of that row in a single timed cycle. Parallel mode and the start bit both clear themselves when that cycle ends.

Top module: `eeprom_write_ctrl`

## Requirements
- R1: The control register is at `reg_sel`=1. Its bits are: bit0 write enable, bit2 row-parallel enable, bit3 start, bit6 standby. Bits 4, 5 and 7 are ignored. A read returns only the busy flag in bit1, with every other bit 0, so it reads 00h after reset.
- R2: An array write while write enable is 0 leaves the array unchanged and does not raise busy.
- R3: In byte mode, an accepted array write raises busy at the clock edge that takes it. Busy then stays high for exactly PROG_CYCLES cycles, and the byte is in the array once busy falls.
- R4: While busy is high, the following have no effect: array writes, and control writes, including attempts to clear write enable. Array reads return 00h. The programming under way still completes.
- R5: When not busy and not in standby, an array read returns the stored byte on `rdata` one cycle after the read strobe. `rdata` holds its value until the next read.
- R6: A control write that sets row-parallel enable from 0 clears all eight latches. In that mode, array writes go to latch `addr[2:0]` and do not raise busy. The first write latches `addr[ADDR_W-1:3]` as the row, and the upper address bits of later writes are ignored.
- R7: A start commits only the latched bytes, each to its row and offset, with busy high for PROG_CYCLES cycles. Afterwards row-parallel mode is off, so the next array write is a byte-mode write.
- R8: A control write with bit3 starts a row commit only if enable and parallel enable are both already 1 and the written value keeps both bits at 1. Otherwise busy stays low and nothing is programmed.
- R9: Clearing row-parallel enable before a start discards the latches. The array is left unchanged.
- R10: While standby is 1, array writes are ignored and array reads return 00h. Clearing standby makes the stored contents readable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 1 selects the control register, 0 selects the array |
| addr | input | ADDR_W | Array byte address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| busy | output | 1 | Programming in progress |

## Verification
The case that matters is a read issued in the last busy cycle, which meets the completion edge where the array is updated. The bench counts busy cycles from the first one and places the read strobe so that the read and the completion edge coincide. The expected result is 00h, because the access is aborted. A read one cycle later must then return the newly programmed byte. Control writes and array writes aimed at that same busy window are judged by the array contents and the busy flag read back after programming ends.

// File: rtl/eeprom_write_ctrl.sv
module eeprom_write_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = ADDR_W - 3;
  localparam int CNT_W = $clog2(PROG_CYCLES);

  logic [7:0]        mem [DEPTH];
  logic [7:0]        lat [8];
  logic [7:0]        lat_mask;
  logic [ROW_W-1:0]  row;
  logic              en, par_en, go, stby;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data;

  wire ctl_wr   = wr && reg_sel && !busy;
  wire arr_wr   = wr && !reg_sel && !busy && en && !stby;
  wire start_ok = ctl_wr && wdata[3] && wdata[0] && wdata[2] && en && par_en;
  wire done     = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < 8; j++) lat[j] <= '0;
      lat_mask  <= '0;
      row       <= '0;
      en        <= 1'b0;
      par_en    <= 1'b0;
      go        <= 1'b0;
      stby      <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      rdata     <= '0;
    end else begin
      if (rd) begin
        if (reg_sel)           rdata <= {6'b0, busy, 1'b0};
        else if (busy || stby) rdata <= '0;
        else                   rdata <= mem[addr];
      end

      if (busy) begin
        if (done) begin
          busy <= 1'b0;
          if (go) begin
            for (int k = 0; k < 8; k++)
              if (lat_mask[k]) mem[{row, 3'(k)}] <= lat[k];
            go       <= 1'b0;
            par_en   <= 1'b0;
            lat_mask <= '0;
          end else begin
            mem[pend_addr] <= pend_data;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (ctl_wr) begin
        en     <= wdata[0];
        par_en <= wdata[2];
        stby   <= wdata[6];
        if (!(wdata[2] && par_en)) lat_mask <= '0;
        if (start_ok) begin
          go   <= 1'b1;
          busy <= 1'b1;
          cnt  <= CNT_W'(PROG_CYCLES - 1);
        end
      end else if (arr_wr) begin
        if (par_en) begin
          lat[addr[2:0]]      <= wdata;
          lat_mask[addr[2:0]] <= 1'b1;
          if (lat_mask == '0) row <= addr[ADDR_W-1:3];
        end else begin
          pend_addr <= addr;
          pend_data <= wdata;
          busy      <= 1'b1;
          cnt       <= CNT_W'(PROG_CYCLES - 1);
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_write_ctrl_chk.sv
module eeprom_write_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       busy,
  input logic       en,
  input logic       par_en
);
  assert_no_busy_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !reg_sel && !busy && !en) |=> !busy);

  assert_ctl_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_sel && busy) |=> $stable(en));

  assert_read_aborted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !reg_sel && busy) |=> (rdata == 8'h00));

  assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_sel && !busy && !(en && par_en)) |=> !busy);

  assert_busy_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr));

  assert_ctl_read_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && reg_sel) |=> ((rdata & 8'hFD) == 8'h00));
endmodule

bind eeprom_write_ctrl eeprom_write_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr(wr), .rd(rd),
  .wdata(wdata), .rdata(rdata), .busy(busy), .en(en), .par_en(par_en)
);

// File: tb/tb_eeprom_write_ctrl.sv
module tb_eeprom_write_ctrl;
  localparam int AW = 6;
  localparam int P  = 12;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy;
  logic [7:0] model [N];
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_write_ctrl #(.ADDR_W(AW), .PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .busy(busy));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input int a, input int d);
    @(negedge clk);
    reg_sel = sel; addr = AW'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, input int a, output int d);
    @(negedge clk);
    reg_sel = sel; addr = AW'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic busy_len(output int len);
    len = 0;
    while (busy) begin len++; @(negedge clk); end
  endtask

  initial begin
    int v, len;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset busy", busy, 0);
    bus_rd(1'b1, 0, v); chk("R1 ctl reads 00h after reset", v, 8'h00);
    bus_wr(1'b1, 0, 8'hF5);
    bus_rd(1'b1, 0, v); chk("R1 write-only bits read 0", v, 8'h00);
    bus_wr(1'b1, 0, 8'h00);

    bus_wr(1'b0, 5, 8'hAA);
    chk("R2 no busy when disabled", busy, 0);
    bus_rd(1'b0, 5, v); chk("R2 array unchanged", v, 8'h00);

    bus_wr(1'b1, 0, 8'h01);
    bus_wr(1'b0, 9, 8'h3C); model[9] = 8'h3C;
    busy_len(len); chk("R3 busy length", len, P);
    bus_rd(1'b0, 9, v); chk("R3 R5 byte programmed", v, 8'h3C);

    bus_wr(1'b0, 10, 8'h71); model[10] = 8'h71;
    chk("R3 busy raised", busy, 1);
    bus_wr(1'b0, 11, 8'hEE);
    bus_wr(1'b1, 0, 8'h00);
    bus_rd(1'b0, 9, v); chk("R4 read aborted while busy", v, 8'h00);
    bus_rd(1'b1, 0, v); chk("R1 R4 ctl shows busy", v, 8'h02);
    while (busy) @(negedge clk);
    bus_rd(1'b0, 10, v); chk("R4 pending write completes", v, 8'h71);
    bus_rd(1'b0, 11, v); chk("R4 write during busy dropped", v, 8'h00);
    bus_wr(1'b0, 12, 8'h5A); model[12] = 8'h5A;
    chk("R4 enable survived locked write", busy, 1);
    while (busy) @(negedge clk);

    bus_wr(1'b0, 13, 8'hC3); model[13] = 8'hC3;
    for (int k = 1; k < P - 1; k++) @(negedge clk);
    bus_rd(1'b0, 13, v); chk("R4 read at completion edge aborted", v, 8'h00);
    chk("R3 busy low after completion", busy, 0);
    bus_rd(1'b0, 13, v); chk("R5 read after completion", v, 8'hC3);

    for (int a = 0; a < N; a++) begin
      bus_wr(1'b0, a, (a * 37 + 5) & 8'hFF); model[a] = 8'((a * 37 + 5) & 8'hFF);
      while (busy) @(negedge clk);
    end
    for (int a = 0; a < N; a++) begin
      bus_rd(1'b0, a, v); chk("R3 R5 sweep", v, model[a]);
    end

    bus_wr(1'b1, 0, 8'h05);
    bus_wr(1'b0, 25, 8'h11); chk("R6 latch write no busy", busy, 0);
    bus_wr(1'b0, 28, 8'h44);
    bus_wr(1'b0, 31, 8'h77);
    bus_wr(1'b0, 50, 8'h22);
    bus_rd(1'b0, 25, v); chk("R6 array untouched before start", v, model[25]);
    bus_wr(1'b1, 0, 8'h0D);
    busy_len(len); chk("R7 row commit busy length", len, P);
    model[25] = 8'h11; model[26] = 8'h22; model[28] = 8'h44; model[31] = 8'h77;
    for (int a = 25; a < 32; a++)
      if (a != 27 && a != 29 && a != 30) begin
        bus_rd(1'b0, a, v); chk("R6 R7 latched byte committed", v, model[a]);
      end
    bus_rd(1'b0, 50, v); chk("R6 upper bits ignored", v, model[50]);
    bus_wr(1'b0, 0, 8'h99); model[0] = 8'h99;
    chk("R7 parallel mode cleared", busy, 1);
    while (busy) @(negedge clk);
    bus_rd(1'b0, 0, v); chk("R7 byte mode after commit", v, 8'h99);

    bus_wr(1'b1, 0, 8'h09);
    chk("R8 start without parallel enable", busy, 0);
    bus_wr(1'b1, 0, 8'h04);
    bus_wr(1'b1, 0, 8'h0C);
    chk("R8 start without enable", busy, 0);
    bus_wr(1'b1, 0, 8'h05);
    bus_wr(1'b1, 0, 8'h09);
    chk("R8 start clearing parallel enable", busy, 0);

    bus_wr(1'b1, 0, 8'h05);
    bus_wr(1'b0, 40, 8'hAB);
    bus_wr(1'b1, 0, 8'h01);
    bus_wr(1'b1, 0, 8'h05);
    bus_wr(1'b1, 0, 8'h0D);
    busy_len(len); chk("R9 empty commit still timed", len, P);
    bus_rd(1'b0, 40, v); chk("R9 discarded latch", v, model[40]);

    bus_wr(1'b1, 0, 8'h41);
    bus_wr(1'b0, 3, 8'h00);
    chk("R10 standby write no busy", busy, 0);
    bus_rd(1'b0, 3, v); chk("R10 standby read 00h", v, 8'h00);
    bus_wr(1'b1, 0, 8'h01);
    bus_rd(1'b0, 3, v); chk("R10 contents kept", v, model[3]);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule